// File: doc/BRIEF.md
# BCD Alarm Comparator with Wildcard Fields

This block watches the current time of a 24-hour BCD clock and raises a one-cycle alarm pulse when the time agrees with a set of programmed alarm fields. Five byte-wide alarm fields cover seconds, minutes, hours, day of month and month. The day and month fields are optional extensions chosen at build time. With both present, an alarm can be placed up to a year ahead. With neither, the alarm repeats every day on hours, minutes and seconds alone.

Any field can be made a "match anything" wildcard. Every field treats a value of 0xC0 or above as a wildcard. The day and month fields also treat zero as a wildcard. A field value that is neither a legal time value nor a wildcard never matches. Software loads the fields through a simple byte write port. The clock counter supplies the already-advanced time together with a once-per-second update strobe. The comparison is made only in strobe cycles. The resulting pulse feeds an interrupt flag unit.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset the alarm pulse is low, the seconds, minutes and hours fields hold 0x00, and the day and month fields hold 0x00 (wildcard).
- R2: The alarm pulse goes high for exactly one cycle, in the cycle after an update strobe cycle in which every field matches. Without a strobe it stays low.
- R3: A seconds or minutes field below 0x60 matches only an identical current value.
- R4: An hours field below 0x24 matches only an identical current hour.
- R5: In any field, a value from 0xC0 to 0xFF matches every current value.
- R6: A seconds or minutes field from 0x60 to 0xBF, or an hours field from 0x24 to 0xBF, never matches.
- R7: Below 0xC0, the day field uses only its low six bits and ignores bits 7:6. A low part of zero is a wildcard, a low part up to 0x31 must equal the current day, and a larger low part never matches.
- R8: The month field treats 0x00 as a wildcard. Values 0x01 to 0x12 must equal the current month, and 0x13 to 0xBF never match.
- R9: When the day and month extensions are disabled by parameter, matching ignores the current day and month and the contents of those fields.
- R10: An alarm write in the same cycle as an update strobe does not affect that strobe's comparison. It takes effect from the next strobe.
- R11: Write select 0 addresses seconds, 1 minutes, 2 hours, 3 day and 4 month. Selects 5 to 7 change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_tick | input | 1 | Once-per-second strobe; the time inputs already show the new second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hour, BCD 24-hour |
| now_mday | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| alm_wr_en | input | 1 | Alarm field write strobe |
| alm_wr_sel | input | 3 | Alarm field select |
| alm_wr_data | input | 8 | Alarm field write byte |
| alarm_pulse | output | 1 | One-cycle alarm event |

## Verification
A field write and an update strobe can land in the same cycle. The bench provokes this by issuing a seconds write with the strobe asserted. The old seconds value matches the current time and the new one does not. A pulse after that strobe shows the comparison used the old value. Later strobes at the old and then the new second show that the new value took over from the next strobe onward.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  localparam int unsigned NUM_FIELDS = 5;
  localparam int unsigned SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DAY  = 3'd3,
    SEL_MON  = 3'd4
  } alm_sel_e;

  typedef enum logic [1:0] {
    FK_MINSEC,
    FK_HOUR,
    FK_DAY,
    FK_MON
  } field_kind_e;

  function automatic field_kind_e kind_of(input int idx);
    case (idx)
      0, 1:    return FK_MINSEC;
      2:       return FK_HOUR;
      3:       return FK_DAY;
      default: return FK_MON;
    endcase
  endfunction

endpackage

// File: rtl/alarm_field_regs.sv
module alarm_field_regs
  import alarm_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter bit          EXT_DAY = 1'b1,
  parameter bit          EXT_MON = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [DW-1:0]                   wr_data,
  output logic [NUM_FIELDS-1:0][DW-1:0]   alm_q
);

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    localparam bit PRESENT = (gi < 3) || (gi == 3 && EXT_DAY) || (gi == 4 && EXT_MON);
    if (PRESENT) begin : g_on
      logic          we;
      logic [DW-1:0] fld_d;
      logic [DW-1:0] fld_q;

      always_comb begin
        we    = wr_en && (wr_sel == SEL_W'(gi));
        fld_d = we ? wr_data : fld_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= '0;
        else        fld_q <= fld_d;
      end

      assign alm_q[gi] = fld_q;

      // R11: a write to this field's select is captured
      assert_write_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(wr_sel) == SEL_W'(gi)) |-> fld_q == $past(wr_data));
    end else begin : g_off
      assign alm_q[gi] = '0;
    end
  end

endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import alarm_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter field_kind_e KIND = FK_MINSEC
) (
  input  logic [DW-1:0] alm,
  input  logic [DW-1:0] cur,
  output logic          hit
);

  localparam logic [DW-1:0] WILD_FLOOR = {2'b11, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] MS_LIMIT   = DW'(8'h60);
  localparam logic [DW-1:0] HR_LIMIT   = DW'(8'h24);
  localparam logic [DW-1:0] DAY_MAX    = DW'(8'h31);
  localparam logic [DW-1:0] MON_MAX    = DW'(8'h12);

  logic          wild;
  logic [DW-1:0] day_low;

  always_comb begin
    wild    = (alm >= WILD_FLOOR);
    day_low = {2'b00, alm[DW-3:0]};
    hit     = 1'b0;
    case (KIND)
      FK_MINSEC: hit = wild || (alm < MS_LIMIT && alm == cur);
      FK_HOUR:   hit = wild || (alm < HR_LIMIT && alm == cur);
      FK_DAY:    hit = wild || (day_low == '0) ||
                       (day_low <= DAY_MAX && day_low == cur);
      default:   hit = wild || (alm == '0) ||
                       (alm <= MON_MAX && alm == cur);
    endcase
  end

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter bit          EXT_DAY = 1'b1,
  parameter bit          EXT_MON = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_tick,
  input  logic [DW-1:0]    now_sec,
  input  logic [DW-1:0]    now_min,
  input  logic [DW-1:0]    now_hour,
  input  logic [DW-1:0]    now_mday,
  input  logic [DW-1:0]    now_month,
  input  logic             alm_wr_en,
  input  logic [SEL_W-1:0] alm_wr_sel,
  input  logic [DW-1:0]    alm_wr_data,
  output logic             alarm_pulse
);

  logic [NUM_FIELDS-1:0][DW-1:0] alm_q;
  logic [NUM_FIELDS-1:0][DW-1:0] now_bus;
  logic [NUM_FIELDS-1:0]         hit;
  logic                          pulse_d;
  logic                          pulse_q;

  assign now_bus = {now_month, now_mday, now_hour, now_min, now_sec};

  alarm_field_regs #(
    .DW      (DW),
    .EXT_DAY (EXT_DAY),
    .EXT_MON (EXT_MON)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (alm_wr_en),
    .wr_sel  (alm_wr_sel),
    .wr_data (alm_wr_data),
    .alm_q   (alm_q)
  );

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
    localparam bit PRESENT = (gi < 3) || (gi == 3 && EXT_DAY) || (gi == 4 && EXT_MON);
    if (PRESENT) begin : g_on
      alarm_field_cmp #(
        .DW   (DW),
        .KIND (kind_of(gi))
      ) u_cmp (
        .alm (alm_q[gi]),
        .cur (now_bus[gi]),
        .hit (hit[gi])
      );
    end else begin : g_off
      assign hit[gi] = 1'b1;
    end
  end

  always_comb begin
    pulse_d = upd_tick && (&hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign alarm_pulse = pulse_q;

  assert_pulse_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(upd_tick));

  assert_sec_agrees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> ($past(alm_q[0]) >= DW'(8'hC0) || $past(alm_q[0]) == $past(now_sec)));

  assert_hour_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> ($past(alm_q[2]) < DW'(8'h24) || $past(alm_q[2]) >= DW'(8'hC0)));

  if (EXT_MON) begin : g_mon_chk
    assert_month_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> !($past(alm_q[4]) > DW'(8'h12) && $past(alm_q[4]) < DW'(8'hC0)));
  end

endmodule

// File: tb/alarm_match_unit_bench.sv
module alarm_match_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;

  typedef struct packed {
    logic [7:0] a_s, a_m, a_h, a_d, a_o;
    logic [7:0] c_s, c_m, c_h, c_d, c_o;
    logic       ex;
    logic       ex_hms;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h30, 8'h15, 8'h08, 8'h00, 8'h00, 8'h30, 8'h15, 8'h08, 8'h12, 8'h05, 1'b1, 1'b1}, // R3 R4 R7 R8
    '{8'h30, 8'h15, 8'h08, 8'h00, 8'h00, 8'h31, 8'h15, 8'h08, 8'h12, 8'h05, 1'b0, 1'b0}, // R3
    '{8'h30, 8'h15, 8'h08, 8'h00, 8'h00, 8'h30, 8'h16, 8'h08, 8'h12, 8'h05, 1'b0, 1'b0}, // R3
    '{8'h30, 8'h15, 8'h08, 8'h00, 8'h00, 8'h30, 8'h15, 8'h09, 8'h12, 8'h05, 1'b0, 1'b0}, // R4
    '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h47, 8'h59, 8'h23, 8'h31, 8'h12, 1'b1, 1'b1}, // R5
    '{8'hC0, 8'hC5, 8'hE3, 8'hC1, 8'hFE, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 1'b1, 1'b1}, // R5
    '{8'h60, 8'h00, 8'h00, 8'h00, 8'h00, 8'h60, 8'h00, 8'h00, 8'h01, 8'h01, 1'b0, 1'b0}, // R6
    '{8'h00, 8'h00, 8'h24, 8'h00, 8'h00, 8'h00, 8'h00, 8'h24, 8'h01, 8'h01, 1'b0, 1'b0}, // R6
    '{8'h10, 8'h20, 8'h12, 8'h15, 8'h06, 8'h10, 8'h20, 8'h12, 8'h15, 8'h06, 1'b1, 1'b1}, // R7 R8
    '{8'h10, 8'h20, 8'h12, 8'h15, 8'h06, 8'h10, 8'h20, 8'h12, 8'h16, 8'h06, 1'b0, 1'b1}, // R7 R9
    '{8'h10, 8'h20, 8'h12, 8'h55, 8'h06, 8'h10, 8'h20, 8'h12, 8'h15, 8'h06, 1'b1, 1'b1}, // R7 upper bits
    '{8'h10, 8'h20, 8'h12, 8'h40, 8'h06, 8'h10, 8'h20, 8'h12, 8'h22, 8'h06, 1'b1, 1'b1}, // R7 zero low
    '{8'h10, 8'h20, 8'h12, 8'h32, 8'h06, 8'h10, 8'h20, 8'h12, 8'h32, 8'h06, 1'b0, 1'b1}, // R7 too big
    '{8'h10, 8'h20, 8'h12, 8'h15, 8'h11, 8'h10, 8'h20, 8'h12, 8'h15, 8'h12, 1'b0, 1'b1}, // R8
    '{8'h10, 8'h20, 8'h12, 8'h15, 8'h13, 8'h10, 8'h20, 8'h12, 8'h15, 8'h13, 1'b0, 1'b1}, // R8 invalid
    '{8'h10, 8'h20, 8'h12, 8'h15, 8'hBF, 8'h10, 8'h20, 8'h12, 8'h15, 8'hBF, 1'b0, 1'b1}  // R8 invalid
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       upd_tick;
  logic [7:0] now_sec, now_min, now_hour, now_mday, now_month;
  logic       alm_wr_en;
  logic [2:0] alm_wr_sel;
  logic [7:0] alm_wr_data;
  logic       alarm_pulse;
  logic       alarm_pulse_hms;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_unit u_alarm_match_unit (
    .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_mday(now_mday), .now_month(now_month),
    .alm_wr_en(alm_wr_en), .alm_wr_sel(alm_wr_sel), .alm_wr_data(alm_wr_data),
    .alarm_pulse(alarm_pulse)
  );

  alarm_match_unit #(.EXT_DAY(1'b0), .EXT_MON(1'b0)) u_alarm_match_unit_hms (
    .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_mday(now_mday), .now_month(now_month),
    .alm_wr_en(alm_wr_en), .alm_wr_sel(alm_wr_sel), .alm_wr_data(alm_wr_data),
    .alarm_pulse(alarm_pulse_hms)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    alm_wr_en = 1'b1; alm_wr_sel = sel; alm_wr_data = data;
    @(negedge clk);
    alm_wr_en = 1'b0;
  endtask

  task automatic set_now(input logic [7:0] s, m, h, d, o);
    now_sec = s; now_min = m; now_hour = h; now_mday = d; now_month = o;
  endtask

  // leaves the caller at the negedge where the pulse is visible
  task automatic tick_at(input logic [7:0] s, m, h, d, o);
    @(negedge clk);
    set_now(s, m, h, d, o);
    upd_tick = 1'b1;
    @(negedge clk);
    upd_tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; upd_tick = 1'b0;
    alm_wr_en = 1'b0; alm_wr_sel = '0; alm_wr_data = '0;
    set_now(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    repeat (3) @(negedge clk);
    check("R1 pulse low in reset", alarm_pulse, 1'b0);
    rst_n = 1'b1;

    // R1: reset fields give midnight, any day and month
    tick_at(8'h00, 8'h00, 8'h00, 8'h17, 8'h09);
    check("R1 reset fields match midnight", alarm_pulse, 1'b1);
    check("R1 reset fields match midnight hms", alarm_pulse_hms, 1'b1);
    @(negedge clk);
    check("R2 single cycle pulse", alarm_pulse, 1'b0);
    @(negedge clk);
    set_now(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    repeat (2) @(negedge clk);
    check("R2 no pulse without tick", alarm_pulse, 1'b0);

    // Vector table: R3 to R9, writes through R11 mapping
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd0, VECS[i].a_s);
      wr(3'd1, VECS[i].a_m);
      wr(3'd2, VECS[i].a_h);
      wr(3'd3, VECS[i].a_d);
      wr(3'd4, VECS[i].a_o);
      tick_at(VECS[i].c_s, VECS[i].c_m, VECS[i].c_h, VECS[i].c_d, VECS[i].c_o);
      check($sformatf("vector %0d full (R3-R8 set)", i), alarm_pulse, VECS[i].ex);
      check($sformatf("vector %0d R9 hms-only", i), alarm_pulse_hms, VECS[i].ex_hms);
      @(negedge clk);
      check($sformatf("vector %0d R2 pulse drops", i), alarm_pulse, 1'b0);
    end

    // R10: write during strobe cycle
    wr(3'd0, 8'h05); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    @(negedge clk);
    set_now(8'h05, 8'h00, 8'h00, 8'h01, 8'h01);
    upd_tick = 1'b1;
    alm_wr_en = 1'b1; alm_wr_sel = 3'd0; alm_wr_data = 8'h06;
    @(negedge clk);
    upd_tick = 1'b0; alm_wr_en = 1'b0;
    check("R10 old value used at colliding strobe", alarm_pulse, 1'b1);
    tick_at(8'h05, 8'h00, 8'h00, 8'h01, 8'h01);
    check("R10 old value gone next strobe", alarm_pulse, 1'b0);
    tick_at(8'h06, 8'h00, 8'h00, 8'h01, 8'h01);
    check("R10 new value active next strobe", alarm_pulse, 1'b1);

    // R11: selects 5..7 change nothing
    wr(3'd5, 8'h99); wr(3'd6, 8'h99); wr(3'd7, 8'h99);
    tick_at(8'h06, 8'h00, 8'h00, 8'h01, 8'h01);
    check("R11 unused selects ignored", alarm_pulse, 1'b1);
    check("R11 unused selects ignored hms", alarm_pulse_hms, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule